// File: doc/BRIEF.md
# Channel Command Word Sequencer

This block is the control core of an I/O data channel. It works through a chain of command words held in a shared memory of 36-bit words, on behalf of one device unit at a time. A CPU first selects a unit and a transfer direction. It then hands the channel the memory location of the first command. From that point the channel runs without the CPU. It fetches a command and loads an operation code, a word count and a data address from it. It then moves one data word per device handshake between the device and ascending memory locations.

When the count of a command reaches zero, the operation code decides what happens next. The channel either fetches the command stored at the following location or disconnects. Disconnecting releases the unit and returns the channel to idle. Every data word passes through a single data register on its way between the device and memory, whichever way it flows. The memory port is a request held until acknowledged. The device port is a ready/strobe pair.

Top module: `iochan_sequencer`

## Requirements
- R1: After reset, busy, mem_req and dev_rdy are all low.
- R2: A cpu_sel pulse while idle makes busy high and drives the pulsed cpu_unit on dev_unit. A cpu_start pulse while idle with no prior select is ignored: busy and mem_req stay low. The channel never requests memory and offers a device handshake in the same cycle.
- R3: A cpu_start pulse after a select fetches a command by a memory read at cpu_cmd_addr. The command's fields are: operation code in bits [35:33], word count in bits [32:18], starting data address in bits [14:0]. Bits [17:15] are ignored.
- R4: With cpu_dir_in=1 (device to memory), each dev_strobe taken while dev_rdy is high captures dev_rdata. That word is then written to memory at the current data address. Writes go to consecutive ascending addresses, exactly word-count times per command.
- R5: With cpu_dir_in=0 (memory to device), the channel reads memory at consecutive ascending addresses. It presents each word on dev_wdata with dev_rdy high until a dev_strobe takes it, exactly word-count times per command.
- R6: When a command with operation code 3'b001 reaches a count of zero, the channel fetches the next command from the location just after the previous command. When a command with code 3'b000 reaches zero, the channel disconnects and busy falls.
- R7: A command with any operation code other than 3'b000 or 3'b001 disconnects at once, with no data transfer.
- R8: A command loaded with a word count of zero transfers no data. It then chains or disconnects according to its operation code, as in R6.
- R9: The data address wraps from 15'h7FFF to 15'h0000.
- R10: While busy, further cpu_sel and cpu_start pulses are ignored. dev_unit, the direction and the command chain are unaffected.
- R11: The memory request holds its address, write enable and write data stable until mem_ack. In the device-to-memory direction, the word written is the one captured at the strobe, even if dev_rdata changes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Unit select pulse from the CPU |
| cpu_unit | input | 4 | Unit number captured on select |
| cpu_dir_in | input | 1 | Direction captured on select: 1 device to memory, 0 memory to device |
| cpu_start | input | 1 | Start pulse carrying the first command location |
| cpu_cmd_addr | input | 15 | Location of the first command |
| busy | output | 1 | High from select until disconnect |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 36 | Write data (data register) |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 36 | Read data, valid with mem_ack |
| dev_unit | output | 4 | Selected unit |
| dev_rdy | output | 1 | Channel ready to trade one word with the device |
| dev_strobe | input | 1 | Device trades one word this cycle |
| dev_rdata | input | 36 | Word from the device |
| dev_wdata | output | 36 | Word to the device (data register) |

## Verification
On every cycle the assertions check four things. They check that a pending memory request holds steady and that memory and device are never addressed together. They check that each transferred word steps the count down and the address up by one, and that each fetch advances the command location by one. They check that the unit, the direction and the command location stay put while busy and that busy falls only through a disconnect. Only the bench's scenarios show the end results: that chained commands visit the right locations, that zero counts and unknown codes skip the transfer, that addresses wrap, and that device words arrive in memory or on the device in order.

// File: rtl/iochan_pkg.sv
package iochan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_FETCH,
    ST_DECIDE,
    ST_DEV_IN,
    ST_MEM_WR,
    ST_MEM_RD,
    ST_DEV_OUT
  } chan_state_t;

  localparam logic [2:0] OP_XFER_STOP  = 3'b000;
  localparam logic [2:0] OP_XFER_CHAIN = 3'b001;

  function automatic logic op_moves_data(input logic [2:0] op);
    return (op == OP_XFER_STOP) || (op == OP_XFER_CHAIN);
  endfunction

  function automatic logic op_chains(input logic [2:0] op);
    return op == OP_XFER_CHAIN;
  endfunction

endpackage

// File: rtl/iochan_ctrl.sv
module iochan_ctrl
  import iochan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_sel,
  input  logic       cpu_start,
  input  logic       mem_ack,
  input  logic       dev_strobe,
  input  logic       dir_in,
  input  logic       cnt_zero,
  input  logic [2:0] op,
  output logic       busy,
  output logic       mem_req,
  output logic       mem_we,
  output logic       addr_from_clc,
  output logic       dev_rdy,
  output logic       sel_evt,
  output logic       start_evt,
  output logic       fetch_evt,
  output logic       xfer_evt,
  output logic       cap_dev,
  output logic       cap_mem,
  output logic       disc_evt
);

  chan_state_t state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d   = state_q;
    sel_evt   = 1'b0;
    start_evt = 1'b0;
    fetch_evt = 1'b0;
    xfer_evt  = 1'b0;
    cap_dev   = 1'b0;
    cap_mem   = 1'b0;
    disc_evt  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cpu_sel) begin
        sel_evt = 1'b1;
        state_d = ST_SEL;
      end
      ST_SEL: if (cpu_start) begin
        start_evt = 1'b1;
        state_d   = ST_FETCH;
      end
      ST_FETCH: if (mem_ack) begin
        fetch_evt = 1'b1;
        state_d   = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (!op_moves_data(op)) begin
          disc_evt = 1'b1;
          state_d  = ST_IDLE;
        end else if (cnt_zero) begin
          if (op_chains(op)) state_d = ST_FETCH;
          else begin
            disc_evt = 1'b1;
            state_d  = ST_IDLE;
          end
        end else begin
          state_d = dir_in ? ST_DEV_IN : ST_MEM_RD;
        end
      end
      ST_DEV_IN: if (dev_strobe) begin
        cap_dev = 1'b1;
        state_d = ST_MEM_WR;
      end
      ST_MEM_WR: if (mem_ack) begin
        xfer_evt = 1'b1;
        state_d  = ST_DECIDE;
      end
      ST_MEM_RD: if (mem_ack) begin
        cap_mem = 1'b1;
        state_d = ST_DEV_OUT;
      end
      ST_DEV_OUT: if (dev_strobe) begin
        xfer_evt = 1'b1;
        state_d  = ST_DECIDE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_req       = (state_q == ST_FETCH) || (state_q == ST_MEM_WR) || (state_q == ST_MEM_RD);
  assign mem_we        = (state_q == ST_MEM_WR);
  assign addr_from_clc = (state_q == ST_FETCH);
  assign dev_rdy       = (state_q == ST_DEV_IN) || (state_q == ST_DEV_OUT);

  // R2: memory and device are never engaged in the same cycle
  a_r2_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && dev_rdy));

  // R11: a pending request keeps its direction until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));

  // R6: busy only drops through a disconnect
  a_r6_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(disc_evt));

  // R7: an unknown operation code never leads to a device handshake
  a_r7_no_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECIDE && !op_moves_data(op)) |=> !busy);

endmodule

// File: rtl/iochan_cmd_regs.sv
module iochan_cmd_regs #(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 15,
  parameter int UNIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              sel_evt,
  input  logic [UNIT_W-1:0] cpu_unit,
  input  logic              cpu_dir_in,
  input  logic              start_evt,
  input  logic [ADDR_W-1:0] cpu_cmd_addr,
  input  logic              fetch_evt,
  input  logic [2:0]        cmd_op,
  input  logic [CNT_W-1:0]  cmd_cnt,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              xfer_evt,
  input  logic              addr_from_clc,
  output logic [2:0]        op,
  output logic              cnt_zero,
  output logic              dir_in,
  output logic [UNIT_W-1:0] unit,
  output logic [ADDR_W-1:0] mem_addr
);

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - 1'b1;
  endfunction

  logic [2:0]        op_q;
  logic [CNT_W-1:0]  wcnt_q;
  logic [ADDR_W-1:0] dac_q;
  logic [ADDR_W-1:0] clc_q;
  logic [UNIT_W-1:0] unit_q;
  logic              dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_q <= '0;
      dir_q  <= 1'b0;
    end else if (sel_evt) begin
      unit_q <= cpu_unit;
      dir_q  <= cpu_dir_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         clc_q <= '0;
    else if (start_evt) clc_q <= cpu_cmd_addr;
    else if (fetch_evt) clc_q <= addr_step(clc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      wcnt_q <= '0;
      dac_q  <= '0;
    end else if (fetch_evt) begin
      op_q   <= cmd_op;
      wcnt_q <= cmd_cnt;
      dac_q  <= cmd_addr;
    end else if (xfer_evt) begin
      wcnt_q <= cnt_step(wcnt_q);
      dac_q  <= addr_step(dac_q);
    end
  end

  assign op       = op_q;
  assign cnt_zero = (wcnt_q == '0);
  assign dir_in   = dir_q;
  assign unit     = unit_q;
  assign mem_addr = addr_from_clc ? clc_q : dac_q;

  // R4, R9: each moved word steps count down and address up, modulo the width
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> (wcnt_q == $past(wcnt_q) - 1'b1) && (dac_q == $past(dac_q) + 1'b1));

  // R6: every fetch moves the command location to the following word
  a_r6_next_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |=> (clc_q == $past(clc_q) + 1'b1));

  // R10: unit and direction cannot change while busy
  a_r10_unit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sel_evt) |=> ($stable(unit_q) && $stable(dir_q)));

  // R10: command location only moves by start or fetch
  a_r10_clc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_evt && !fetch_evt) |=> $stable(clc_q));

endmodule

// File: rtl/iochan_dreg.sv
module iochan_dreg #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_dev,
  input  logic [WORD_W-1:0] dev_rdata,
  input  logic              cap_mem,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_r <= '0;
    else if (cap_dev) q_r <= dev_rdata;
    else if (cap_mem) q_r <= mem_rdata;
  end

  assign q = q_r;

  // R11: the staged word holds until the next capture
  a_r11_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_dev || cap_mem) |=> $stable(q_r));

endmodule

// File: rtl/iochan_sequencer.sv
module iochan_sequencer #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 15,
  parameter int UNIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic [UNIT_W-1:0] cpu_unit,
  input  logic              cpu_dir_in,
  input  logic              cpu_start,
  input  logic [ADDR_W-1:0] cpu_cmd_addr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [UNIT_W-1:0] dev_unit,
  output logic              dev_rdy,
  input  logic              dev_strobe,
  input  logic [WORD_W-1:0] dev_rdata,
  output logic [WORD_W-1:0] dev_wdata
);

  localparam int OP_W   = 3;
  localparam int OP_LO  = WORD_W - OP_W;
  localparam int CNT_LO = OP_LO - CNT_W;

  logic       sel_evt, start_evt, fetch_evt, xfer_evt;
  logic       cap_dev, cap_mem, disc_evt;
  logic       addr_from_clc, dir_in, cnt_zero;
  logic [2:0] op;
  logic [WORD_W-1:0] stage_q;

  iochan_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_sel      (cpu_sel),
    .cpu_start    (cpu_start),
    .mem_ack      (mem_ack),
    .dev_strobe   (dev_strobe),
    .dir_in       (dir_in),
    .cnt_zero     (cnt_zero),
    .op           (op),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .addr_from_clc(addr_from_clc),
    .dev_rdy      (dev_rdy),
    .sel_evt      (sel_evt),
    .start_evt    (start_evt),
    .fetch_evt    (fetch_evt),
    .xfer_evt     (xfer_evt),
    .cap_dev      (cap_dev),
    .cap_mem      (cap_mem),
    .disc_evt     (disc_evt)
  );

  iochan_cmd_regs #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .UNIT_W(UNIT_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .sel_evt      (sel_evt),
    .cpu_unit     (cpu_unit),
    .cpu_dir_in   (cpu_dir_in),
    .start_evt    (start_evt),
    .cpu_cmd_addr (cpu_cmd_addr),
    .fetch_evt    (fetch_evt),
    .cmd_op       (mem_rdata[WORD_W-1:OP_LO]),
    .cmd_cnt      (mem_rdata[OP_LO-1:CNT_LO]),
    .cmd_addr     (mem_rdata[ADDR_W-1:0]),
    .xfer_evt     (xfer_evt),
    .addr_from_clc(addr_from_clc),
    .op           (op),
    .cnt_zero     (cnt_zero),
    .dir_in       (dir_in),
    .unit         (dev_unit),
    .mem_addr     (mem_addr)
  );

  iochan_dreg #(
    .WORD_W(WORD_W)
  ) u_dreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_dev  (cap_dev),
    .dev_rdata(dev_rdata),
    .cap_mem  (cap_mem),
    .mem_rdata(mem_rdata),
    .q        (stage_q)
  );

  assign mem_wdata = stage_q;
  assign dev_wdata = stage_q;

  // R11: address and write data of a pending request stay put until acknowledged
  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata)));

endmodule

// File: tb/iochan_sequencer_test.sv
`timescale 1ns/1ps
module iochan_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_sel = 1'b0;
  logic [3:0]  cpu_unit = '0;
  logic        cpu_dir_in = 1'b0;
  logic        cpu_start = 1'b0;
  logic [14:0] cpu_cmd_addr = '0;
  logic        busy, mem_req, mem_we, dev_rdy;
  logic [14:0] mem_addr;
  logic [35:0] mem_wdata, dev_wdata;
  logic        mem_ack = 1'b0;
  logic [35:0] mem_rdata = '0;
  logic [3:0]  dev_unit;
  logic        dev_strobe = 1'b0;
  logic [35:0] dev_rdata = '0;

  always #4 clk = ~clk;

  iochan_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_unit(cpu_unit),
    .cpu_dir_in(cpu_dir_in), .cpu_start(cpu_start), .cpu_cmd_addr(cpu_cmd_addr),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_unit(dev_unit), .dev_rdy(dev_rdy), .dev_strobe(dev_strobe),
    .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
  );

  int checks = 0;
  int fails  = 0;

  logic [35:0] mem [0:1023];
  logic [14:0] wlog_addr [0:63];
  logic [35:0] wlog_data [0:63];
  logic [14:0] rlog_addr [0:63];
  logic [35:0] olog_data [0:63];
  int wlog_n = 0, rlog_n = 0, olog_n = 0, din_n = 0;
  bit dir_in_b = 1'b0;

  function automatic logic [35:0] mk_cmd(input logic [2:0] op, input logic [14:0] cnt,
                                         input logic [14:0] addr);
    return {op, cnt, 3'b101, addr};
  endfunction

  function automatic logic [35:0] din_word(input int k);
    logic [35:0] w;
    w = 36'h9_0000_0000 ^ (36'(k) << 20) ^ 36'(k * 7 + 3);
    return w;
  endfunction

  function automatic logic [35:0] pat(input logic [14:0] a);
    return {6'h2A, 15'(a * 3), a};
  endfunction

  function automatic logic [14:0] nth_addr(input logic [14:0] base, input int i);
    return 15'(base + 15'(i));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory and device models, acting at the falling edge
  always @(negedge clk) begin
    mem_ack    = 1'b0;
    dev_strobe = 1'b0;
    dev_rdata  = {4'($urandom), $urandom};
    if (rst_n && mem_req && ($urandom_range(2, 0) != 0)) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mem[mem_addr[9:0]] = mem_wdata;
        if (wlog_n < 64) begin
          wlog_addr[wlog_n] = mem_addr;
          wlog_data[wlog_n] = mem_wdata;
        end
        wlog_n++;
      end else begin
        mem_rdata = mem[mem_addr[9:0]];
        if (rlog_n < 64) rlog_addr[rlog_n] = mem_addr;
        rlog_n++;
      end
    end
    if (rst_n && dev_rdy && ($urandom_range(1, 0) == 1)) begin
      dev_strobe = 1'b1;
      if (dir_in_b) begin
        dev_rdata = din_word(din_n);
        din_n++;
      end else begin
        if (olog_n < 64) olog_data[olog_n] = dev_wdata;
        olog_n++;
      end
    end
  end

  task automatic clear_logs();
    wlog_n = 0; rlog_n = 0; olog_n = 0; din_n = 0;
  endtask

  task automatic do_select(input logic [3:0] u, input bit din);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_unit = u; cpu_dir_in = din; dir_in_b = din;
    @(negedge clk);
    cpu_sel = 1'b0;
  endtask

  task automatic do_start(input logic [14:0] a);
    @(negedge clk);
    cpu_start = 1'b1; cpu_cmd_addr = a;
    @(negedge clk);
    cpu_start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    bit ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) begin ok = 1'b1; break; end
    end
    chk(ok, req, "disconnect reached", 64'(busy), 64'd0);
  endtask

  // checks writes against device words 0.. at two address runs
  task automatic chk_writes(input string req, input logic [14:0] b1, input int n1,
                            input logic [14:0] b2, input int n2);
    chk(wlog_n == n1 + n2, req, "write count", 64'(wlog_n), 64'(n1 + n2));
    for (int i = 0; i < n1 + n2 && i < 64 && i < wlog_n; i++) begin
      logic [14:0] ea;
      ea = (i < n1) ? nth_addr(b1, i) : nth_addr(b2, i - n1);
      chk(wlog_addr[i] == ea, req, "write address", 64'(wlog_addr[i]), 64'(ea));
      chk(wlog_data[i] == din_word(i), req, "write data", 64'(wlog_data[i]), 64'(din_word(i)));
    end
  endtask

  task automatic chk_outputs(input string req, input logic [14:0] b1, input int n1,
                             input logic [14:0] b2, input int n2);
    chk(olog_n == n1 + n2, req, "device word count", 64'(olog_n), 64'(n1 + n2));
    chk(wlog_n == 0, req, "no memory writes", 64'(wlog_n), 64'd0);
    for (int i = 0; i < n1 + n2 && i < 64 && i < olog_n; i++) begin
      logic [14:0] ea;
      ea = (i < n1) ? nth_addr(b1, i) : nth_addr(b2, i - n1);
      chk(olog_data[i] == pat(ea), req, "device word", 64'(olog_data[i]), 64'(pat(ea)));
    end
  endtask

  task automatic preload(input logic [14:0] b, input int n);
    for (int i = 0; i < n; i++) mem[nth_addr(b, i) & 15'h3FF] = pat(nth_addr(b, i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy at reset", 64'(busy), 64'd0);
    chk(mem_req == 1'b0, "R1", "mem_req at reset", 64'(mem_req), 64'd0);
    chk(dev_rdy == 1'b0, "R1", "dev_rdy at reset", 64'(dev_rdy), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: start without select is ignored
    do_start(15'h300);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R2", "busy after lone start", 64'(busy), 64'd0);
    chk(mem_req == 1'b0, "R2", "mem_req after lone start", 64'(mem_req), 64'd0);

    // R2, R3, R4: single input command
    mem[10'h300] = mk_cmd(3'b000, 15'd4, 15'h0100);
    clear_logs();
    do_select(4'd5, 1'b1);
    chk(busy == 1'b1, "R2", "busy after select", 64'(busy), 64'd1);
    chk(dev_unit == 4'd5, "R2", "dev_unit after select", 64'(dev_unit), 64'd5);
    do_start(15'h300);
    wait_idle("R4");
    chk(rlog_n == 1 && rlog_addr[0] == 15'h300, "R3", "fetch location",
        64'(rlog_addr[0]), 64'h300);
    chk_writes("R4", 15'h0100, 4, 15'h0, 0);

    // R5, R6: output chain of two commands
    mem[10'h310] = mk_cmd(3'b001, 15'd2, 15'h0180);
    mem[10'h311] = mk_cmd(3'b000, 15'd3, 15'h01A0);
    preload(15'h0180, 2);
    preload(15'h01A0, 3);
    clear_logs();
    do_select(4'd2, 1'b0);
    do_start(15'h310);
    wait_idle("R6");
    chk_outputs("R5", 15'h0180, 2, 15'h01A0, 3);
    chk(rlog_n == 7 && rlog_addr[3] == 15'h311, "R6", "second fetch location",
        64'(rlog_addr[3]), 64'h311);

    // R8: zero counts chain and disconnect without transfer
    mem[10'h320] = mk_cmd(3'b001, 15'd0, 15'h0050);
    mem[10'h321] = mk_cmd(3'b001, 15'd1, 15'h0200);
    mem[10'h322] = mk_cmd(3'b000, 15'd0, 15'h0060);
    clear_logs();
    do_select(4'd7, 1'b1);
    do_start(15'h320);
    wait_idle("R8");
    chk(rlog_n == 3, "R8", "fetch count", 64'(rlog_n), 64'd3);
    chk(rlog_addr[1] == 15'h321 && rlog_addr[2] == 15'h322, "R8", "fetch sequence",
        {rlog_addr[1], rlog_addr[2]}, {15'h321, 15'h322});
    chk_writes("R8", 15'h0200, 1, 15'h0, 0);

    // R7: unknown code disconnects without transfer
    mem[10'h330] = mk_cmd(3'b101, 15'd3, 15'h0240);
    clear_logs();
    do_select(4'd1, 1'b1);
    do_start(15'h330);
    wait_idle("R7");
    chk(wlog_n == 0 && din_n == 0, "R7", "no words moved", 64'(wlog_n + din_n), 64'd0);
    chk(rlog_n == 1, "R7", "single fetch", 64'(rlog_n), 64'd1);

    // R9: address wrap
    mem[10'h334] = mk_cmd(3'b000, 15'd3, 15'h7FFE);
    clear_logs();
    do_select(4'd4, 1'b1);
    do_start(15'h334);
    wait_idle("R9");
    chk_writes("R9", 15'h7FFE, 3, 15'h0, 0);

    // R10: select and start while busy are ignored
    mem[10'h340] = mk_cmd(3'b000, 15'd6, 15'h0140);
    preload(15'h0140, 6);
    clear_logs();
    do_select(4'd3, 1'b0);
    do_start(15'h340);
    repeat (6) @(negedge clk);
    cpu_sel = 1'b1; cpu_unit = 4'd9; cpu_dir_in = 1'b1;
    cpu_start = 1'b1; cpu_cmd_addr = 15'h330;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_start = 1'b0;
    chk(busy == 1'b1, "R10", "still busy", 64'(busy), 64'd1);
    chk(dev_unit == 4'd3, "R10", "unit kept", 64'(dev_unit), 64'd3);
    wait_idle("R10");
    chk_outputs("R10", 15'h0140, 6, 15'h0, 0);
    chk(rlog_addr[0] == 15'h340 && rlog_n == 7, "R10", "chain unchanged",
        64'(rlog_n), 64'd7);

    // random chains of two commands (R4, R5, R6, R11)
    for (int it = 0; it < 6; it++) begin
      bit din;
      int n1, n2;
      logic [14:0] b1, b2, ca;
      din = 1'($urandom_range(1, 0));
      n1  = $urandom_range(5, 1);
      n2  = $urandom_range(5, 1);
      b1  = 15'($urandom_range(32'h1F0, 0));
      b2  = 15'(b1 + 15'h40);
      ca  = 15'(15'h350 + 15'(it * 2));
      mem[ca & 15'h3FF]               = mk_cmd(3'b001, 15'(n1), b1);
      mem[nth_addr(ca, 1) & 15'h3FF]  = mk_cmd(3'b000, 15'(n2), b2);
      if (!din) begin
        preload(b1, n1);
        preload(b2, n2);
      end
      clear_logs();
      do_select(4'($urandom_range(15, 0)), din);
      do_start(ca);
      wait_idle("R6");
      if (din) chk_writes("R11", b1, n1, b2, n2);
      else     chk_outputs("R5", b1, n1, b2, n2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule